// File: doc/BRIEF.md
# Line Error Counter Bank

This block gathers the error indications of a framed serial line receiver and turns them into counts that software can read. A framer delivers seven single-cycle event pulses: framing bit errors, bipolar violations, CRC errors, out-of-frame events, change-of-frame-alignment events, multiframe out-of-sync events and excessive-zero events. Each pulse advances its own counter. The first three counters are wide and the other four are narrow.

For every counter there is a pending event flag and a sticky overflow flag. Each flag has its own enable mask, and the unmasked flags are ORed onto one interrupt line. Software uses a small register port to preset any counter, clear flags, set the masks and drive a control word. The control word can clear all counters on a rising edge of one bit. It also lets an externally generated one-second tick copy six of the counters into shadow latches, with an option to restart the live counts at each copy.

All state is registered on the rising clock edge. The read data is a combinational function of the address.

Top module: `lecb_top`

## Requirements
- R1: Counters 0 (framing bit), 1 (bipolar violation) and 2 (CRC) are 16 bits wide. Counters 3 (out-of-frame), 4 (alignment change), 5 (multiframe out-of-sync) and 6 (excessive zeros) are 8 bits wide. A pulse on `err_evt[k]` adds one to counter k at the next edge, and an all-ones counter wraps to zero. Counter k reads at address k.
- R2: `irq` is high exactly when some bit is set in (event flags AND event mask, address 0x12), or in (overflow flags AND overflow mask, address 0x13), or when the one-second flag and control bit 3 are both set. A mask bit of 1 enables its source.
- R3: The event flag register (address 0x10, bit k for counter k) sets bit k on each pulse of `err_evt[k]`. Writing 1 to a bit clears it. A pulse in the same cycle as that write leaves the bit set.
- R4: The overflow latch register (address 0x11, bit k) sets bit k when counter k wraps because of an event, and the bit stays set until software writes 1 to it. A wrap in the same cycle as that write leaves the bit set.
- R5: A write to address k loads counter k with the low bits of `bus_wdata`. When an event hits the same counter in that cycle, the written value wins.
- R6: The cycle after control bit 2 (address 0x14) changes from 0 to 1, every counter becomes zero. Writing that bit again while it is already 1 has no effect, and holding it at 1 has no effect either.
- R7: When `sec_tick` is high and control bit 0 (sample enable) is set, latches 0 to 5 (addresses 0x08 to 0x0D) take the value their counters held before that edge. At any other time the latches hold. Address 0x0E (excessive zeros) always reads 0.
- R8: When control bit 1 (auto-clear) is set, a snapshot also restarts counters 0 to 5. A counter restarts at 0, or at 1 if its event arrives in the same cycle, and no overflow is flagged. Counter 6 is not affected.
- R9: Every `sec_tick` pulse sets the one-second flag (address 0x15, bit 0), and writing 1 to that bit clears it. A tick in the same cycle as the write leaves the flag set.
- R10: After reset, every register, counter, latch and flag reads zero and `irq` is low. Unused addresses read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| err_evt | input | 7 | Single-cycle error pulses, bit k advances counter k |
| sec_tick | input | 1 | One-cycle pulse marking each second |
| bus_wr | input | 1 | Write strobe for the register port |
| bus_addr | input | 5 | Register address for reads and writes |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr`, combinational |
| irq | output | 1 | OR of all unmasked pending flags |

## Verification
Several behaviours are checked on every cycle, whatever the traffic:
- `irq` stays low while every mask is clear.
- An event pulse always shows up in its flag.
- A sticky overflow bit only drops through a write of 1.
- A preset value appears in the counter at the next edge.
- The latches hold between sampled ticks.
- A counter is zero after a clear edge.

Other cases depend on one exact cycle, so only the bench scenarios show them:
- The collision priorities: a write against an event, and a W1C against a new wrap.
- The level-insensitivity of the clear bit.
- The restart at 1 under auto-clear.
- The value each latch captures from before the edge.

// File: rtl/lecb_pkg.sv
`timescale 1ns/1ps
// Package: shared constants and types for the line error counter bank.
// Assumes a fixed set of seven counters, the first three of them wide.
package lecb_pkg;
    localparam int NCNT   = 7;
    localparam int N_WIDE = 3;
    localparam int ADDR_W = 5;

    localparam logic [ADDR_W-1:0] A_LAT_BASE = 5'h08;
    localparam logic [ADDR_W-1:0] A_EVF      = 5'h10;
    localparam logic [ADDR_W-1:0] A_OVF      = 5'h11;
    localparam logic [ADDR_W-1:0] A_EVM      = 5'h12;
    localparam logic [ADDR_W-1:0] A_OVM      = 5'h13;
    localparam logic [ADDR_W-1:0] A_CTRL     = 5'h14;
    localparam logic [ADDR_W-1:0] A_SECF     = 5'h15;

    // Counters that own a one-second shadow latch (all but excessive zeros)
    localparam logic [NCNT-1:0] LATCHED = 7'b0111111;

    // Control word, bit 0 is sample_en
    typedef struct packed {
        logic irq_sec_en;
        logic clr;
        logic auto_clr;
        logic sample_en;
    } ctrl_t;
endpackage

// File: rtl/lecb_counter.sv
`timescale 1ns/1ps
// Module: one error counter with an optional one-second shadow latch.
// Priority per edge: software load, then global clear, then snapshot
// restart, then event increment. Assumes evt is a single-cycle pulse.
// ovf_o is a combinational pulse for the cycle in which an event wraps.
module lecb_counter #(
    parameter int W         = 16,
    parameter bit HAS_LATCH = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_sel,
    input  logic [W-1:0] wr_val,
    input  logic         clr_all,
    input  logic         snap,
    input  logic         auto_clr,
    input  logic         evt,
    output logic [W-1:0] cnt_o,
    output logic [W-1:0] lat_o,
    output logic         ovf_o
);
    localparam logic [W-1:0] ALL_ONES = '1;
    localparam logic [W-1:0] ONE      = W'(1);

    logic [W-1:0] cnt_q;
    logic [W-1:0] cnt_d;
    logic         snap_clr;

    assign snap_clr = HAS_LATCH && snap && auto_clr;

    // Next count selection by priority
    always_comb begin
        cnt_d = cnt_q;
        ovf_o = 1'b0;
        if (wr_sel) begin
            cnt_d = wr_val;
        end else if (clr_all) begin
            cnt_d = '0;
        end else if (snap_clr) begin
            cnt_d = evt ? ONE : '0;
        end else if (evt) begin
            cnt_d = cnt_q + ONE;
            ovf_o = (cnt_q == ALL_ONES);
        end
    end

    // Live counter register
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt_o = cnt_q;

    generate
        if (HAS_LATCH) begin : g_latch
            logic [W-1:0] lat_q;
            // Shadow latch captures the pre-edge count on a sampled tick
            always_ff @(posedge clk) begin
                if (!rst_n)    lat_q <= '0;
                else if (snap) lat_q <= cnt_q;
            end
            assign lat_o = lat_q;
        end else begin : g_nolatch
            assign lat_o = '0;
        end
    endgenerate
endmodule

// File: rtl/lecb_regs.sv
`timescale 1ns/1ps
// Module: control, mask and flag registers of the counter bank.
// Holds the event and overflow flags (write-1-to-clear, set wins), the two
// mask registers, the control word with clear-edge detection, and the
// one-second flag. Also forms the interrupt line.
module lecb_regs
    import lecb_pkg::*;
#(
    parameter int N = NCNT
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [N-1:0]      wbits,
    input  logic [N-1:0]      evt,
    input  logic [N-1:0]      ovf_pulse,
    input  logic              tick,
    output ctrl_t             ctrl_o,
    output logic              clr_rise,
    output logic [N-1:0]      ev_flag_o,
    output logic [N-1:0]      ov_flag_o,
    output logic [N-1:0]      ev_mask_o,
    output logic [N-1:0]      ov_mask_o,
    output logic              sec_flag_o,
    output logic              irq
);
    logic [N-1:0] ev_clr;
    logic [N-1:0] ov_clr;
    logic         sec_clr;
    logic         clr_prev;

    assign ev_clr  = (wr && addr == A_EVF)  ? wbits    : '0;
    assign ov_clr  = (wr && addr == A_OVF)  ? wbits    : '0;
    assign sec_clr = wr && addr == A_SECF && wbits[0];

    // Mask registers, one enable bit per counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_mask_o <= '0;
            ov_mask_o <= '0;
        end else if (wr) begin
            if (addr == A_EVM) ev_mask_o <= wbits;
            if (addr == A_OVM) ov_mask_o <= wbits;
        end
    end

    // Control word and previous value of its clear bit
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_o   <= '0;
            clr_prev <= 1'b0;
        end else begin
            clr_prev <= ctrl_o.clr;
            if (wr && addr == A_CTRL) ctrl_o <= ctrl_t'(wbits[3:0]);
        end
    end

    assign clr_rise = ctrl_o.clr && !clr_prev;

    // Pending event flags, new events beat the clear
    always_ff @(posedge clk) begin
        if (!rst_n) ev_flag_o <= '0;
        else        ev_flag_o <= (ev_flag_o & ~ev_clr) | evt;
    end

    // Sticky overflow latch, new wraps beat the clear
    always_ff @(posedge clk) begin
        if (!rst_n) ov_flag_o <= '0;
        else        ov_flag_o <= (ov_flag_o & ~ov_clr) | ovf_pulse;
    end

    // One-second flag
    always_ff @(posedge clk) begin
        if (!rst_n) sec_flag_o <= 1'b0;
        else        sec_flag_o <= (sec_flag_o && !sec_clr) || tick;
    end

    // Interrupt line from all unmasked pending sources
    always_comb begin
        irq = (|(ev_flag_o & ev_mask_o)) || (|(ov_flag_o & ov_mask_o))
              || (sec_flag_o && ctrl_o.irq_sec_en);
    end
endmodule

// File: rtl/lecb_top.sv
`timescale 1ns/1ps
// Module: line error counter bank top.
// Generates one counter per error source, with the first N_WIDE counters
// WIDE_W bits wide and the rest NARROW_W bits wide, attaches the register
// block, and decodes the read port. Assumes NARROW_W <= WIDE_W and
// err_evt bits are single-cycle pulses.
module lecb_top
    import lecb_pkg::*;
#(
    parameter int WIDE_W   = 16,
    parameter int NARROW_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCNT-1:0]     err_evt,
    input  logic                sec_tick,
    input  logic                bus_wr,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [WIDE_W-1:0]   bus_wdata,
    output logic [WIDE_W-1:0]   bus_rdata,
    output logic                irq
);
    localparam int DW = WIDE_W;

    logic [DW-1:0]   cnt_ext [NCNT];
    logic [DW-1:0]   lat_ext [NCNT];
    logic [NCNT-1:0] ovf_pulse;
    logic [NCNT-1:0] ev_flag;
    logic [NCNT-1:0] ov_flag;
    logic [NCNT-1:0] ev_mask;
    logic [NCNT-1:0] ov_mask;
    logic            sec_flag;
    logic            clr_rise;
    logic            snap;
    ctrl_t           ctrl;

    assign snap = sec_tick && ctrl.sample_en;

    generate
        for (genvar k = 0; k < NCNT; k++) begin : g_cnt
            localparam int W = (k < N_WIDE) ? WIDE_W : NARROW_W;
            logic [W-1:0] c;
            logic [W-1:0] l;
            lecb_counter #(
                .W        (W),
                .HAS_LATCH(LATCHED[k])
            ) u_cnt (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_sel  (bus_wr && bus_addr == ADDR_W'(k)),
                .wr_val  (bus_wdata[W-1:0]),
                .clr_all (clr_rise),
                .snap    (snap),
                .auto_clr(ctrl.auto_clr),
                .evt     (err_evt[k]),
                .cnt_o   (c),
                .lat_o   (l),
                .ovf_o   (ovf_pulse[k])
            );
            assign cnt_ext[k] = DW'(c);
            assign lat_ext[k] = DW'(l);
        end
    endgenerate

    lecb_regs #(.N(NCNT)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr        (bus_wr),
        .addr      (bus_addr),
        .wbits     (bus_wdata[NCNT-1:0]),
        .evt       (err_evt),
        .ovf_pulse (ovf_pulse),
        .tick      (sec_tick),
        .ctrl_o    (ctrl),
        .clr_rise  (clr_rise),
        .ev_flag_o (ev_flag),
        .ov_flag_o (ov_flag),
        .ev_mask_o (ev_mask),
        .ov_mask_o (ov_mask),
        .sec_flag_o(sec_flag),
        .irq       (irq)
    );

    // Read decode: counters, latches, then the register block
    always_comb begin
        bus_rdata = '0;
        if (bus_addr < ADDR_W'(NCNT)) begin
            bus_rdata = cnt_ext[bus_addr[2:0]];
        end else if (bus_addr[4:3] == A_LAT_BASE[4:3] && bus_addr[2:0] < 3'(NCNT)) begin
            bus_rdata = lat_ext[bus_addr[2:0]];
        end else begin
            case (bus_addr)
                A_EVF:   bus_rdata = DW'(ev_flag);
                A_OVF:   bus_rdata = DW'(ov_flag);
                A_EVM:   bus_rdata = DW'(ev_mask);
                A_OVM:   bus_rdata = DW'(ov_mask);
                A_CTRL:  bus_rdata = DW'(ctrl);
                A_SECF:  bus_rdata = DW'(sec_flag);
                default: bus_rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/lecb_checker.sv
`timescale 1ns/1ps
// Module: assertion checker for lecb_top, attached by bind below.
// Observes ports and the signals passed between the counters and the
// register block.
module lecb_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        bus_wr,
    input logic [4:0]  bus_addr,
    input logic [15:0] bus_wdata,
    input logic        evt0,
    input logic        sec_tick,
    input logic [15:0] cnt0,
    input logic [15:0] cnt1,
    input logic [15:0] lat0,
    input logic [6:0]  ev_flag,
    input logic [6:0]  ov_flag,
    input logic [6:0]  ev_mask,
    input logic [6:0]  ov_mask,
    input logic        ctrl_sample,
    input logic        ctrl_sec,
    input logic        clr_rise,
    input logic        irq
);
    // R2: no enabled source means no interrupt
    a_r2_irq_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_mask == '0 && ov_mask == '0 && !ctrl_sec) |-> !irq);

    // R3: an event pulse is always visible in its flag
    a_r3_evt_flag: assert property (@(posedge clk) disable iff (!rst_n)
        evt0 |=> ev_flag[0]);

    // R4: overflow bit is sticky until a write of one
    a_r4_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ov_flag[0] && !(bus_wr && bus_addr == 5'h11 && bus_wdata[0])) |=> ov_flag[0]);

    // R5: preset value lands in the counter
    a_r5_preset: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 5'd1) |=> (cnt1 == $past(bus_wdata)));

    // R6: clear edge zeroes a counter not being written
    a_r6_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_rise && !(bus_wr && bus_addr == 5'd0)) |=> (cnt0 == '0));

    // R7: latch holds without a sampled tick
    a_r7_latch_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(sec_tick && ctrl_sample) |=> $stable(lat0));
endmodule

bind lecb_top lecb_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .evt0       (err_evt[0]),
    .sec_tick   (sec_tick),
    .cnt0       (cnt_ext[0]),
    .cnt1       (cnt_ext[1]),
    .lat0       (lat_ext[0]),
    .ev_flag    (ev_flag),
    .ov_flag    (ov_flag),
    .ev_mask    (ev_mask),
    .ov_mask    (ov_mask),
    .ctrl_sample(ctrl.sample_en),
    .ctrl_sec   (ctrl.irq_sec_en),
    .clr_rise   (clr_rise),
    .irq        (irq)
);

// File: tb/test_lecb_top.sv
`timescale 1ns/1ps
// Bench: behavioural reference model updated on each rising edge, with
// every readable register and irq compared on every clock.
module test_lecb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  evt = '0;
    logic        tick = 1'b0;
    logic        wr = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    wire  [15:0] rdata;
    wire         irq;

    always #2.5 clk = ~clk;

    lecb_top i_lecb_top (
        .clk(clk), .rst_n(rst_n), .err_evt(evt), .sec_tick(tick),
        .bus_wr(wr), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .irq(irq)
    );

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;

    // reference state
    int m_cnt [7];
    int m_lat [7];
    int m_evf, m_ovf, m_evm, m_ovm, m_ctrl, m_sec, m_clrp;
    int t_ov, t_rise, t_snap, t_ac, t_wa, t_wd;

    function automatic int maxv(int k);
        return (k < 3) ? 65535 : 255;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 7; k++) begin m_cnt[k] = 0; m_lat[k] = 0; end
            m_evf = 0; m_ovf = 0; m_evm = 0; m_ovm = 0; m_ctrl = 0; m_sec = 0; m_clrp = 0;
        end else begin
            t_wa = wr ? int'(addr) : -1;
            t_wd = int'(wdata);
            t_rise = ((m_ctrl & 4) != 0) && (m_clrp == 0);
            t_snap = tick && ((m_ctrl & 1) != 0);
            t_ac = (m_ctrl & 2) != 0;
            t_ov = 0;
            for (int k = 0; k < 7; k++) begin
                if (t_snap && k < 6) m_lat[k] = m_cnt[k];
                if (t_wa == k) m_cnt[k] = t_wd & maxv(k);
                else if (t_rise) m_cnt[k] = 0;
                else if (t_snap && t_ac && k < 6) m_cnt[k] = evt[k] ? 1 : 0;
                else if (evt[k]) begin
                    if (m_cnt[k] == maxv(k)) begin m_cnt[k] = 0; t_ov |= (1 << k); end
                    else m_cnt[k] = m_cnt[k] + 1;
                end
            end
            m_clrp = (m_ctrl & 4) ? 1 : 0;
            if (t_wa == 16) m_evf &= ~t_wd;
            m_evf = (m_evf | int'(evt)) & 127;
            if (t_wa == 17) m_ovf &= ~t_wd;
            m_ovf = (m_ovf | t_ov) & 127;
            if (t_wa == 21 && (t_wd & 1)) m_sec = 0;
            if (tick) m_sec = 1;
            if (t_wa == 18) m_evm = t_wd & 127;
            if (t_wa == 19) m_ovm = t_wd & 127;
            if (t_wa == 20) m_ctrl = t_wd & 15;
        end
    end

    function automatic int model_read(int a);
        if (a < 7) return m_cnt[a];
        if (a >= 8 && a < 14) return m_lat[a-8];
        case (a)
            16: return m_evf;
            17: return m_ovf;
            18: return m_evm;
            19: return m_ovm;
            20: return m_ctrl;
            21: return m_sec;
            default: return 0;
        endcase
    endfunction

    function automatic string req_of(int a);
        if (a < 7) return "R1";
        if (a >= 8 && a < 15) return "R7";
        case (a)
            16: return "R3";
            17: return "R4";
            18, 19: return "R2";
            21: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic check(int act, int exp, string tag);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        int m_irq;
        for (int a = 0; a < 32; a++) begin
            addr = 5'(a);
            #0.02;
            check(int'(rdata), model_read(a), req_of(a));
        end
        m_irq = ((m_evf & m_evm) != 0 || (m_ovf & m_ovm) != 0 || (m_sec != 0 && (m_ctrl & 8) != 0)) ? 1 : 0;
        check(int'(irq), m_irq, "R2 irq");
    endtask

    task automatic step(logic [6:0] e, logic w, logic [4:0] a, logic [15:0] d, logic t);
        @(negedge clk);
        wr = 1'b0; evt = '0; tick = 1'b0;
        compare_all();
        evt = e; wr = w; addr = a; wdata = d; tick = t;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step('0, 1'b0, 5'd0, 16'd0, 1'b0);
    endtask

    task automatic wreg(logic [4:0] a, logic [15:0] d);
        step('0, 1'b1, a, d, 1'b0);
    endtask

    task automatic expect_now(logic [4:0] a, int exp, string tag);
        addr = a;
        #0.02;
        check(int'(rdata), exp, tag);
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    endtask

    // watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected < 100000", cyc);
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(1);
        expect_now(5'h14, 0, "R10 reset ctrl");
        check(int'(irq), 0, "R10 reset irq");

        wreg(5'h12, 16'h7f);
        wreg(5'h13, 16'h7f);

        // R5: write beats an event on the same counter
        step(7'h08, 1'b1, 5'd3, 16'h00fe, 1'b0);
        idle(1); expect_now(5'd3, 'hfe, "R5 write wins");
        step(7'h08, 1'b0, 5'd0, 16'd0, 1'b0);
        step(7'h08, 1'b0, 5'd0, 16'd0, 1'b0);
        idle(1);
        expect_now(5'd3, 0, "R1 narrow wrap");
        expect_now(5'h11, 'h08, "R4 overflow latched");

        // R4: new wrap beats a write-1-to-clear
        wreg(5'd3, 16'h00ff);
        step(7'h08, 1'b1, 5'h11, 16'h0008, 1'b0);
        idle(1); expect_now(5'h11, 'h08, "R4 set wins");
        wreg(5'h11, 16'h7f);
        idle(1); expect_now(5'h11, 0, "R4 w1c");

        // R3: event flags clear by write of one
        wreg(5'h10, 16'h7f);
        idle(1); expect_now(5'h10, 0, "R3 w1c");
        check(int'(irq), 0, "R2 nothing pending");

        // R6: clear on rising edge only
        step(7'h7f, 1'b0, 5'd0, 16'd0, 1'b0);
        step(7'h7f, 1'b0, 5'd0, 16'd0, 1'b0);
        wreg(5'h14, 16'h0004);
        idle(2); expect_now(5'd0, 0, "R6 clear edge");
        step(7'h01, 1'b0, 5'd0, 16'd0, 1'b0);
        idle(1); expect_now(5'd0, 1, "R6 level ignored");
        wreg(5'h14, 16'h0004);
        idle(2); expect_now(5'd0, 1, "R6 rewrite ignored");

        // R7, R9: snapshot takes pre-edge value
        wreg(5'h14, 16'h0001);
        step(7'h01, 1'b0, 5'd0, 16'd0, 1'b1);
        idle(1);
        expect_now(5'h08, 1, "R7 latch pre-edge");
        expect_now(5'd0, 2, "R7 live keeps counting");
        expect_now(5'h15, 1, "R9 second flag");

        // R8: auto-clear restarts at one with a coincident event
        wreg(5'h14, 16'h0003);
        step(7'h41, 1'b0, 5'd0, 16'd0, 1'b1);
        idle(1);
        expect_now(5'h08, 2, "R7 latch");
        expect_now(5'd0, 1, "R8 restart at one");
        step('0, 1'b0, 5'd0, 16'd0, 1'b1);
        idle(1);
        expect_now(5'd0, 0, "R8 restart at zero");
        expect_now(5'h0e, 0, "R7 no latch for counter 6");
        expect_now(5'h11, 0, "R8 no overflow");

        // R1: wide wrap
        wreg(5'h14, 16'h0000);
        wreg(5'd0, 16'hffff);
        step(7'h01, 1'b0, 5'd0, 16'd0, 1'b0);
        idle(1);
        expect_now(5'd0, 0, "R1 wide wrap");
        expect_now(5'h11, 1, "R4 wide overflow");

        // R2: all masks off keeps irq low
        wreg(5'h12, 16'h0); wreg(5'h13, 16'h0); wreg(5'h14, 16'h0);
        step(7'h7f, 1'b0, 5'd0, 16'd0, 1'b1);
        idle(1); check(int'(irq), 0, "R2 masked");
        wreg(5'h14, 16'h0008);
        idle(1); check(int'(irq), 1, "R2 second enabled");

        // mixed random traffic
        for (int i = 0; i < 2500; i++) begin
            logic [6:0] e;
            logic w;
            for (int b = 0; b < 7; b++) e[b] = ($urandom % 4) == 0;
            w = ($urandom % 12) == 0;
            step(e, w, 5'($urandom % 22), 16'($urandom),
                 ($urandom % 40) == 0);
        end
        idle(2);

        summary();
        $finish;
    end
endmodule